// File: doc/BRIEF.md
# Delta-Coded Sequential Table Reader

This block reads a constant table that is almost always walked in address order. Each table slot stores a short signed step, not a full word: the gap between that entry's value and the value of the entry before it. Entry 0 is special. Its full-width value sits in a base parameter, and its slot stores zero. A running accumulator adds each fetched step to the value it rebuilt last, so the consumer sees full-width words while the array itself stays narrow.

A user first pulses `start_i`, which loads the base value. Each `next_i` pulse then moves to the following entry. To jump to another entry, the user pulses `restart_i` with a target on `restart_addr_i`. The block then replays the steps from entry 0 and shows `busy_o` until it reaches the target. When a request names the entry that is already on the output, a keeper holds the read address, the accumulator and the output register still. None of the output bus, the adder operands or the adder result changes.

Top module: `delta_rom_reader`

## Requirements
- R1: While reset is asserted and just after it is released, `data_valid_o` is 0, `busy_o` is 0, `addr_o` is 0 and `data_o` is 0.
- R2: When `start_i` is seen at a clock edge (with no `restart_i`, while not busy), then after that edge `data_o` equals `BASE`, `addr_o` is 0 and `data_valid_o` is 1.
- R3: When `next_i` is seen at an edge while valid, not busy and below the last entry, then after that edge `addr_o` has grown by one. `data_o` equals the previous output plus the sign-extended step of the new entry, taken modulo 2^DATA_W.
- R4: The step stored for entry i (1 ≤ i < DEPTH) is the low DELTA_W bits of 13·i+5, read as a two's-complement number. Entry 0 stores 0. Negative steps lower the rebuilt value.
- R5: A `next_i` at the last entry (DEPTH-1) is ignored: `data_o`, `addr_o` and `data_valid_o` stay as they were.
- R6: A request for the entry already on the output leaves `data_o`, `addr_o` and `data_valid_o` unchanged for as long as it is repeated. Such a request is a `restart_i` whose target equals `addr_o`, or a `start_i` while at entry 0.
- R7: A `restart_i` to a target T > 0 sets `busy_o` to 1 and `data_valid_o` to 0 for exactly T cycles after the restart edge. Then `busy_o` is 0, `data_valid_o` is 1, `addr_o` is T and `data_o` equals the full value of entry T.
- R8: A `restart_i` to target 0 acts like `start_i`. A target above DEPTH-1 is clamped to DEPTH-1.
- R9: While `busy_o` is 1, the block ignores `start_i`, `next_i` and `restart_i`. `next_i` before any start leaves `data_valid_o` at 0 and `addr_o` at 0.
- R10: When strobes arrive together, `restart_i` wins over `start_i`, and `start_i` wins over `next_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the base value at entry 0 |
| next_i | input | 1 | Advance to the following entry |
| restart_i | input | 1 | Jump to `restart_addr_i` by replaying the steps |
| restart_addr_i | input | ADDR_W | Restart target entry |
| data_o | output | DATA_W | Rebuilt full-width value |
| data_valid_o | output | 1 | `data_o` holds the value of entry `addr_o` |
| busy_o | output | 1 | Replay in progress |
| addr_o | output | ADDR_W | Entry currently shown |

## Verification
The bench builds the block with DATA_W=12, DELTA_W=6, DEPTH=24 and BASE=100. A depth that is not a power of two leaves restart targets 24 to 31 reachable on a 5-bit address, so the clamp can be exercised. The 6-bit steps include both signs, so a full walk over all 24 entries tests sign extension against a full-width reference table. The short depth keeps every replay length, from 1 up to the clamped maximum of 23, within a short run, together with held repeat reads at both ends of the table.

// File: rtl/delta_rom_pkg.sv
package delta_rom_pkg;

   // Step stored for entry idx: low dw bits of 13*idx+5, two's complement.
   function automatic int step_of(input int idx, input int dw);
      int raw;
      raw = (idx * 13 + 5) % (1 << dw);
      if (raw >= (1 << (dw - 1))) raw = raw - (1 << dw);
      return raw;
   endfunction

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_STEP = 2'd2
   } act_e;

endpackage

// File: rtl/delta_rom.sv
module delta_rom #(
   parameter int DEPTH   = 32,
   parameter int DELTA_W = 6,
   parameter int ADDR_W  = $clog2(DEPTH)
) (
   input  logic [ADDR_W-1:0]  rd_addr_i,
   output logic [DELTA_W-1:0] step_o
);
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);

   logic [DELTA_W-1:0] cells [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      if (i == 0) begin : g_zero
         assign cells[i] = '0;
      end else begin : g_step
         assign cells[i] = DELTA_W'(delta_rom_pkg::step_of(i, DELTA_W));
      end
   end

   assign step_o = (rd_addr_i <= LAST_A) ? cells[rd_addr_i] : '0;
endmodule

// File: rtl/delta_accum.sv
module delta_accum #(
   parameter int                DATA_W  = 16,
   parameter int                DELTA_W = 6,
   parameter logic [DATA_W-1:0] BASE    = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  delta_rom_pkg::act_e act_i,
   input  logic [DELTA_W-1:0] step_i,
   output logic [DATA_W-1:0]  acc_o
);
   localparam int EXT_W = DATA_W - DELTA_W;

   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] step_ext;
   logic [DATA_W-1:0] sum;

   assign step_ext = {{EXT_W{step_i[DELTA_W-1]}}, step_i};
   assign sum      = acc_q + step_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else begin
         unique case (act_i)
            delta_rom_pkg::ACT_LOAD: acc_q <= BASE;
            delta_rom_pkg::ACT_STEP: acc_q <= sum;
            default:                 acc_q <= acc_q;
         endcase
      end
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/delta_seq_ctrl.sv
module delta_seq_ctrl #(
   parameter int DEPTH  = 32,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               next_i,
   input  logic               restart_i,
   input  logic [ADDR_W-1:0]  restart_addr_i,
   output delta_rom_pkg::act_e act_o,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [ADDR_W-1:0]  rom_addr_o,
   output logic               valid_o,
   output logic               busy_o
);
   import delta_rom_pkg::*;

   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);

   logic [ADDR_W-1:0] addr_q, addr_d, tgt_q, tgt_d, tgt_in, addr_inc;
   logic              valid_q, valid_d, busy_q, busy_d;
   act_e              act;

   assign tgt_in   = (restart_addr_i > LAST_A) ? LAST_A : restart_addr_i;
   assign addr_inc = addr_q + 1'b1;

   always_comb begin
      act     = ACT_NONE;
      addr_d  = addr_q;
      valid_d = valid_q;
      busy_d  = busy_q;
      tgt_d   = tgt_q;
      if (busy_q) begin
         act    = ACT_STEP;
         addr_d = addr_inc;
         if (addr_inc == tgt_q) begin
            busy_d  = 1'b0;
            valid_d = 1'b1;
         end
      end else if (restart_i) begin
         if (!(valid_q && tgt_in == addr_q)) begin
            act    = ACT_LOAD;
            addr_d = '0;
            tgt_d  = tgt_in;
            if (tgt_in == '0) begin
               valid_d = 1'b1;
            end else begin
               busy_d  = 1'b1;
               valid_d = 1'b0;
            end
         end
      end else if (start_i) begin
         if (!(valid_q && addr_q == '0)) begin
            act     = ACT_LOAD;
            addr_d  = '0;
            valid_d = 1'b1;
         end
      end else if (next_i && valid_q && addr_q != LAST_A) begin
         act    = ACT_STEP;
         addr_d = addr_inc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         tgt_q   <= '0;
         valid_q <= 1'b0;
         busy_q  <= 1'b0;
      end else begin
         addr_q  <= addr_d;
         tgt_q   <= tgt_d;
         valid_q <= valid_d;
         busy_q  <= busy_d;
      end
   end

   assign act_o      = act;
   assign addr_o     = addr_q;
   assign rom_addr_o = addr_inc;
   assign valid_o    = valid_q;
   assign busy_o     = busy_q;
endmodule

// File: rtl/delta_rom_reader.sv
module delta_rom_reader #(
   parameter int                DATA_W  = 16,
   parameter int                DELTA_W = 6,
   parameter int                DEPTH   = 32,
   parameter logic [DATA_W-1:0] BASE    = DATA_W'(100),
   parameter int                ADDR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              next_i,
   input  logic              restart_i,
   input  logic [ADDR_W-1:0] restart_addr_i,
   output logic [DATA_W-1:0] data_o,
   output logic              data_valid_o,
   output logic              busy_o,
   output logic [ADDR_W-1:0] addr_o
);
   if (DELTA_W < 2 || DELTA_W >= DATA_W) begin : g_bad_width
      $error("delta_rom_reader: DELTA_W must lie in 2..DATA_W-1");
   end
   if (DEPTH < 2 || (1 << ADDR_W) < DEPTH) begin : g_bad_depth
      $error("delta_rom_reader: DEPTH must be >= 2 and fit in ADDR_W");
   end

   delta_rom_pkg::act_e act;
   logic [ADDR_W-1:0]   rom_addr;
   logic [DELTA_W-1:0]  step;

   delta_seq_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .next_i        (next_i),
      .restart_i     (restart_i),
      .restart_addr_i(restart_addr_i),
      .act_o         (act),
      .addr_o        (addr_o),
      .rom_addr_o    (rom_addr),
      .valid_o       (data_valid_o),
      .busy_o        (busy_o)
   );

   delta_rom #(.DEPTH(DEPTH), .DELTA_W(DELTA_W), .ADDR_W(ADDR_W)) u_rom (
      .rd_addr_i(rom_addr),
      .step_o   (step)
   );

   delta_accum #(.DATA_W(DATA_W), .DELTA_W(DELTA_W), .BASE(BASE)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .act_i (act),
      .step_i(step),
      .acc_o (data_o)
   );
endmodule

// File: rtl/delta_rom_reader_chk.sv
module delta_rom_reader_chk #(
   parameter int                DATA_W  = 16,
   parameter int                DEPTH   = 32,
   parameter logic [DATA_W-1:0] BASE    = DATA_W'(100),
   parameter int                ADDR_W  = $clog2(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              next_i,
   input logic              restart_i,
   input logic [ADDR_W-1:0] restart_addr_i,
   input logic [DATA_W-1:0] data_o,
   input logic              data_valid_o,
   input logic              busy_o,
   input logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);

   // R2
   start_loads_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !restart_i && !busy_o) |=> (data_valid_o && addr_o == '0 && data_o == BASE));

   // R3
   next_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (next_i && !start_i && !restart_i && !busy_o && data_valid_o && addr_o != LAST_A)
      |=> (data_valid_o && addr_o == $past(addr_o) + 1'b1));

   // R5
   last_next_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (next_i && !start_i && !restart_i && !busy_o && data_valid_o && addr_o == LAST_A)
      |=> ($stable(data_o) && $stable(addr_o) && data_valid_o));

   // R6
   same_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restart_i && !busy_o && data_valid_o && restart_addr_i == addr_o)
      |=> ($stable(data_o) && $stable(addr_o) && data_valid_o));

   // R7
   busy_hides_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !data_valid_o);

   // R9
   busy_walks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (addr_o == $past(addr_o) + 1'b1));
endmodule

bind delta_rom_reader delta_rom_reader_chk #(
   .DATA_W(DATA_W), .DEPTH(DEPTH), .BASE(BASE), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .next_i(next_i),
   .restart_i(restart_i), .restart_addr_i(restart_addr_i), .data_o(data_o),
   .data_valid_o(data_valid_o), .busy_o(busy_o), .addr_o(addr_o)
);

// File: tb/delta_rom_reader_tb.sv
module delta_rom_reader_tb;
   localparam int DATA_W  = 12;
   localparam int DELTA_W = 6;
   localparam int DEPTH   = 24;
   localparam int ADDR_W  = 5;
   localparam int LAST    = DEPTH - 1;
   localparam logic [DATA_W-1:0] BASE = 12'd100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, next_i = 1'b0, restart_i = 1'b0;
   logic [ADDR_W-1:0] restart_addr_i = '0;
   logic [DATA_W-1:0] data_o;
   logic data_valid_o, busy_o;
   logic [ADDR_W-1:0] addr_o;

   int n_chk = 0;
   int n_err = 0;
   logic [DATA_W-1:0] exp_tab [DEPTH];

   // 200 MHz: 5 ns period, time unit 1 ps
   always #2500 clk = ~clk;

   delta_rom_reader #(
      .DATA_W(DATA_W), .DELTA_W(DELTA_W), .DEPTH(DEPTH), .BASE(BASE), .ADDR_W(ADDR_W)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .next_i(next_i),
      .restart_i(restart_i), .restart_addr_i(restart_addr_i), .data_o(data_o),
      .data_valid_o(data_valid_o), .busy_o(busy_o), .addr_o(addr_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   // Full-width reference table built from the step rule of R4
   task automatic build_ref();
      int v;
      exp_tab[0] = BASE;
      for (int i = 1; i < DEPTH; i++) begin
         v = (i * 13 + 5) % 64;
         if (v >= 32) v = v - 64;
         exp_tab[i] = exp_tab[i-1] + DATA_W'(v);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   task automatic pulse_next();
      @(negedge clk); next_i = 1'b1;
      @(negedge clk); next_i = 1'b0;
   endtask

   task automatic pulse_restart(input int tgt);
      @(negedge clk); restart_i = 1'b1; restart_addr_i = ADDR_W'(tgt);
      @(negedge clk); restart_i = 1'b0;
   endtask

   task automatic wait_idle(output int cnt);
      cnt = 0;
      while (busy_o && cnt < 100) begin
         if (data_valid_o) chk("R7", "valid during busy", 1, 0);
         @(negedge clk);
         cnt++;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "valid in reset", int'(data_valid_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "valid", int'(data_valid_o), 0);
      chk("R1", "busy", int'(busy_o), 0);
      chk("R1", "addr", int'(addr_o), 0);
      chk("R1", "data", int'(data_o), 0);
      pulse_next();
      chk("R9", "valid after early next", int'(data_valid_o), 0);
      chk("R9", "addr after early next", int'(addr_o), 0);
   endtask

   task automatic t_start();
      pulse_start();
      chk("R2", "data", int'(data_o), int'(BASE));
      chk("R2", "valid", int'(data_valid_o), 1);
      chk("R2", "addr", int'(addr_o), 0);
   endtask

   task automatic t_walk();
      for (int i = 1; i < DEPTH; i++) begin
         pulse_next();
         chk("R3 R4", $sformatf("data at %0d", i), int'(data_o), int'(exp_tab[i]));
         chk("R3", $sformatf("addr at %0d", i), int'(addr_o), i);
      end
      pulse_next();
      chk("R5", "data after next at last", int'(data_o), int'(exp_tab[LAST]));
      chk("R5", "addr after next at last", int'(addr_o), LAST);
      chk("R5", "valid after next at last", int'(data_valid_o), 1);
   endtask

   task automatic t_hold();
      logic [DATA_W-1:0] d0;
      d0 = data_o;
      @(negedge clk); restart_i = 1'b1; restart_addr_i = ADDR_W'(LAST);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R6", "held data", int'(data_o), int'(d0));
         chk("R6", "held addr", int'(addr_o), LAST);
         chk("R6", "held busy", int'(busy_o), 0);
      end
      restart_i = 1'b0;
      pulse_restart(0);
      chk("R8", "restart 0 data", int'(data_o), int'(BASE));
      chk("R8", "restart 0 valid", int'(data_valid_o), 1);
      @(negedge clk); start_i = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R6", "start at 0 data", int'(data_o), int'(BASE));
         chk("R6", "start at 0 addr", int'(addr_o), 0);
      end
      start_i = 1'b0;
   endtask

   task automatic t_restart(input int tgt);
      int cnt;
      pulse_restart(tgt);
      chk("R7", "busy after restart", int'(busy_o), 1);
      wait_idle(cnt);
      chk("R7", $sformatf("busy cycles to %0d", tgt), cnt, tgt);
      chk("R7", "data at target", int'(data_o), int'(exp_tab[tgt]));
      chk("R7", "addr at target", int'(addr_o), tgt);
      chk("R7", "valid at target", int'(data_valid_o), 1);
   endtask

   task automatic t_clamp();
      int cnt;
      pulse_restart(30);
      wait_idle(cnt);
      chk("R8", "clamp cycles", cnt, LAST);
      chk("R8", "clamp addr", int'(addr_o), LAST);
      chk("R8", "clamp data", int'(data_o), int'(exp_tab[LAST]));
   endtask

   task automatic t_busy_ignore();
      int cnt;
      pulse_restart(10);
      pulse_start();
      pulse_next();
      pulse_restart(3);
      wait_idle(cnt);
      chk("R9", "addr after ignored strobes", int'(addr_o), 10);
      chk("R9", "data after ignored strobes", int'(data_o), int'(exp_tab[10]));
   endtask

   task automatic t_priority();
      int cnt;
      @(negedge clk);
      start_i = 1'b1; next_i = 1'b1; restart_i = 1'b1; restart_addr_i = 5'd5;
      @(negedge clk);
      start_i = 1'b0; next_i = 1'b0; restart_i = 1'b0;
      chk("R10", "restart wins busy", int'(busy_o), 1);
      wait_idle(cnt);
      chk("R10", "restart wins addr", int'(addr_o), 5);
      chk("R10", "restart wins data", int'(data_o), int'(exp_tab[5]));
      @(negedge clk); start_i = 1'b1; next_i = 1'b1;
      @(negedge clk); start_i = 1'b0; next_i = 1'b0;
      chk("R10", "start over next addr", int'(addr_o), 0);
      chk("R10", "start over next data", int'(data_o), int'(BASE));
   endtask

   initial begin
      build_ref();
      t_reset();
      t_start();
      t_walk();
      t_hold();
      t_restart(7);
      t_restart(1);
      t_clamp();
      t_busy_ignore();
      t_priority();
      repeat (2) @(negedge clk);
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end
endmodule